// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a serial target on a two-wire I2C bus. It lets a host read and write a small bank of divider settings in a clock synthesizer. The block samples the bus clock and data lines with a much faster system clock. From those samples it finds the START, repeated START and STOP conditions, and it frames the bits into bytes. It pulls SDA low through an open-drain enable, both to acknowledge and to send read data. It never drives SCL, so the host's clock is never held low.

The block answers to a seven-bit address. The upper five bits are fixed and the lower two come from strap pins. After a write address, the first data byte loads a register pointer. Each later byte is written through a one-cycle strobe to the register at that pointer, and the pointer then advances. A read sends the byte at the pointer and then advances the pointer, for as long as the host keeps acknowledging.

The register bank is outside this block. It is reached through a write port and a combinational read port that share the pointer as their index. While the parallel-pin configuration mode is selected, incoming data bytes are still acknowledged but are dropped, and reads continue to work.

Top module: `cfgi2c_target`

## Requirements
- R1: The block acknowledges an address byte whose bits 7..1 equal binary 10110 followed by strap_addr[1] and strap_addr[0]. It does so by asserting sda_pull during the ninth SCL clock. Changing the straps changes the address it answers to.
- R2: After an address byte that does not match, the block gives no acknowledge and keeps sda_pull low until the next START.
- R3: Bit 0 of a matching address byte sets the direction. 0 means the host writes bytes to the block, and 1 means the block sends register bytes to the host.
- R4: The first data byte after a write address loads its low PTR_W bits into the register pointer. This byte is acknowledged and produces no write strobe.
- R5: Each later data byte in the same write is acknowledged. It produces exactly one wr_stb pulse, with wr_idx equal to the pointer and wr_byte equal to the byte. The pointer then increments modulo 2^PTR_W.
- R6: While par_sel is high, write data bytes are still acknowledged but produce no wr_stb. The pointer still increments after each such byte.
- R7: In a read, the block sends the byte found at rd_idx (the pointer), MSB first on SDA. It pulses rd_stb and increments the pointer. It sends the next byte for as long as the host acknowledges.
- R8: A NACK from the host ends a read. sda_pull stays low from then until the next START, even if the host keeps clocking.
- R9: A repeated START begins a new address phase, and the pointer keeps its value across transactions.
- R10: A STOP returns the block to idle with sda_pull low. A pointer loaded before the STOP is kept.
- R11: sda_pull changes only while the sampled SCL is low, never during an SCL high phase.
- R12: Reads work in the same way while par_sel is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_addr | input | 2 | Strapped low two bits of the target address |
| par_sel | input | 1 | Parallel-pin configuration mode: host writes are dropped |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_idx | output | PTR_W | Register index for the write |
| wr_byte | output | 8 | Data for the write |
| rd_stb | output | 1 | One-cycle pulse after a register byte has been captured for sending |
| rd_idx | output | PTR_W | Register index whose contents the bank must present |
| rd_byte | input | 8 | Contents of register rd_idx, read combinationally |

## Verification
Two situations are the hardest to reach from the ports. The first is a read burst that the host ends with a NACK and then keeps clocking without a STOP. The second is a write whose data bytes must be acknowledged while par_sel stops them from reaching the bank. The bench reaches the first by clocking a whole further byte after the NACK, while it counts every cycle in which the block pulls SDA. It reaches the second by writing under par_sel and then reading back twice. One read uses the advanced pointer, which shows the increment; the other reloads the pointer, which shows the register kept its old value.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } link_state_t;

    localparam logic [4:0] ADDR_FIXED = 5'b10110;
    localparam int unsigned BYTE_BITS = 8;

    function automatic logic addr_hit(input logic [7:0] b, input logic [1:0] strap);
        return b[7:1] == {ADDR_FIXED, strap};
    endfunction

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LINES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[STAGES-1:0], raw[g]};
        end
        assign level[g] = pipe[STAGES-1];
        assign rise[g]  = pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[g]  = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/cfgi2c_ptr.sv
module cfgi2c_ptr #(
    parameter int unsigned PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic             inc,
    input  logic [PTR_W-1:0] val,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (set) ptr <= val;
        else if (inc) ptr <= ptr + PTR_ONE;
    end

    // R5: an increment advances the pointer by exactly one, wrapping
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (inc && !set) |=> ptr == $past(ptr) + PTR_ONE);

    // R4: a pointer byte lands in the pointer
    a_r4_ptr_load: assert property (@(posedge clk) disable iff (rst)
        set |=> ptr == $past(val));
endmodule

// File: rtl/cfgi2c_link.sv
module cfgi2c_link
    import cfgi2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [1:0] strap,
    input  logic       par_sel,
    input  logic [7:0] rd_byte,
    output logic       sda_pull,
    output logic       wr_stb,
    output logic       rd_stb,
    output logic       ptr_set,
    output logic       ptr_inc,
    output logic [7:0] byte_q
);
    link_state_t state;
    logic [3:0]  cnt;
    logic [7:0]  sh;
    logic        is_addr;
    logic        first_wr;
    logic        rd_mode;
    logic        host_ack;
    logic        start_c;
    logic        stop_c;

    assign start_c = scl_lvl & sda_fall;
    assign stop_c  = scl_lvl & sda_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            is_addr  <= 1'b0;
            first_wr <= 1'b0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            ptr_set  <= 1'b0;
            ptr_inc  <= 1'b0;
            byte_q   <= '0;
        end else begin
            wr_stb  <= 1'b0;
            rd_stb  <= 1'b0;
            ptr_set <= 1'b0;
            ptr_inc <= 1'b0;
            if (start_c) begin
                state    <= ST_RX;
                cnt      <= '0;
                is_addr  <= 1'b1;
                first_wr <= 1'b1;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise && cnt != 4'd8) begin
                            sh  <= {sh[6:0], sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (is_addr) begin
                                if (addr_hit(sh, strap)) begin
                                    state    <= ST_RX_ACK;
                                    sda_pull <= 1'b1;
                                    rd_mode  <= sh[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                state    <= ST_RX_ACK;
                                sda_pull <= 1'b1;
                                byte_q   <= sh;
                                if (first_wr) begin
                                    ptr_set  <= 1'b1;
                                    first_wr <= 1'b0;
                                end else begin
                                    ptr_inc <= 1'b1;
                                    wr_stb  <= !par_sel;
                                end
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            cnt     <= '0;
                            is_addr <= 1'b0;
                            if (is_addr && rd_mode) begin
                                state    <= ST_TX;
                                sh       <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                rd_stb   <= 1'b1;
                                ptr_inc  <= 1'b1;
                            end else begin
                                state    <= ST_RX;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == 4'd7) begin
                                state    <= ST_TX_ACK;
                                sda_pull <= 1'b0;
                            end else begin
                                cnt      <= cnt + 4'd1;
                                sh       <= {sh[6:0], 1'b0};
                                sda_pull <= ~sh[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (host_ack) begin
                                state    <= ST_TX;
                                sh       <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                                rd_stb   <= 1'b1;
                                ptr_inc  <= 1'b1;
                            end else begin
                                state    <= ST_IDLE;
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the data line is only moved while SCL is low
    a_r11_pull_steady_high: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

    // R2 R8: idle never drives the bus
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull);

    // R4: a pointer byte never writes
    a_r4_set_no_write: assert property (@(posedge clk) disable iff (rst)
        ptr_set |-> !wr_stb);

    // R6: no write strobe follows a cycle in parallel mode
    a_r6_par_blocks_write: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $past(!par_sel));

    // R5: write strobe lasts one cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R7: a captured read byte always starts transmission
    a_r7_read_sends: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> state == ST_TX);
endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target #(
    parameter int unsigned PTR_W       = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull,
    input  logic [1:0]       strap_addr,
    input  logic             par_sel,
    output logic             wr_stb,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_byte,
    output logic             rd_stb,
    output logic [PTR_W-1:0] rd_idx,
    input  logic [7:0]       rd_byte
);
    localparam int unsigned IDX_SCL = 0;
    localparam int unsigned IDX_SDA = 1;

    logic [1:0] lvl, rise, fall;
    logic       ptr_set, ptr_inc;
    logic [7:0] byte_q;
    logic [PTR_W-1:0] ptr;

    cfgi2c_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({sda_i, scl_i}),
        .level(lvl),
        .rise (rise),
        .fall (fall)
    );

    cfgi2c_link u_link (
        .clk     (clk),
        .rst     (rst),
        .scl_lvl (lvl[IDX_SCL]),
        .scl_rise(rise[IDX_SCL]),
        .scl_fall(fall[IDX_SCL]),
        .sda_lvl (lvl[IDX_SDA]),
        .sda_rise(rise[IDX_SDA]),
        .sda_fall(fall[IDX_SDA]),
        .strap   (strap_addr),
        .par_sel (par_sel),
        .rd_byte (rd_byte),
        .sda_pull(sda_pull),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .ptr_set (ptr_set),
        .ptr_inc (ptr_inc),
        .byte_q  (byte_q)
    );

    cfgi2c_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk),
        .rst(rst),
        .set(ptr_set),
        .inc(ptr_inc),
        .val(byte_q[PTR_W-1:0]),
        .ptr(ptr)
    );

    assign wr_idx  = ptr;
    assign rd_idx  = ptr;
    assign wr_byte = byte_q;
endmodule

// File: tb/test_cfgi2c_target.sv
module test_cfgi2c_target;
    localparam int Q  = 8;
    localparam int WD = 190000;
    localparam logic [15:0] VEC [8] = '{16'h0011, 16'h01A5, 16'h025C, 16'h03FF,
                                        16'h0400, 16'h0D3C, 16'h0281, 16'h0F7E};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1, sda_h = 1'b1;
    logic [1:0] strap = 2'b01;
    logic par = 1'b0;
    logic sda_pull, wr_stb, rd_stb;
    logic [1:0] wr_idx, rd_idx;
    logic [7:0] wr_byte, rd_byte;
    logic [7:0] bank [4];
    logic [7:0] exp_bank [4];
    logic sda_line;
    int n_chk = 0, n_fail = 0, wr_cnt = 0, pull_cnt = 0, hi_chg = 0;
    bit done = 0;
    logic prev_scl = 1'b1, prev_pull = 1'b0;

    always #2 clk = ~clk;
    assign sda_line = sda_h & ~sda_pull;

    cfgi2c_target i_cfgi2c_target (
        .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line), .sda_pull(sda_pull),
        .strap_addr(strap), .par_sel(par), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_byte(wr_byte), .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    assign rd_byte = bank[rd_idx];
    always @(posedge clk) begin
        if (rst) for (int i = 0; i < 4; i++) bank[i] <= 8'hA0 + 8'(i);
        else if (wr_stb) bank[wr_idx] <= wr_byte;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_stb) wr_cnt++;
            if (sda_pull) pull_cnt++;
            if (scl_h && prev_scl && sda_pull != prev_pull) hi_chg++;
        end
        prev_scl  = scl_h;
        prev_pull = sda_pull;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq; repeat (Q) @(negedge clk); endtask
    task automatic h_start;  sda_h = 0; wq; scl_h = 0; wq; endtask
    task automatic h_stop;   sda_h = 0; wq; scl_h = 1; wq; sda_h = 1; wq; endtask
    task automatic h_rstart; sda_h = 1; wq; scl_h = 1; wq; sda_h = 0; wq; scl_h = 0; wq; endtask

    task automatic h_send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wq; scl_h = 1; wq; wq; scl_h = 0; wq;
        end
        sda_h = 1; wq; scl_h = 1; wq; ack = ~sda_line; wq; scl_h = 0; wq;
    endtask

    task automatic h_recv(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1; wq; scl_h = 1; wq; b[i] = sda_line; wq; scl_h = 0; wq;
        end
        sda_h = ~give_ack; wq; scl_h = 1; wq; wq; scl_h = 0; wq;
    endtask

    function automatic logic [7:0] wa(input logic [1:0] s); return {5'b10110, s, 1'b0}; endfunction
    function automatic logic [7:0] ra(input logic [1:0] s); return {5'b10110, s, 1'b1}; endfunction

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        int w0;
        for (int i = 0; i < 4; i++) exp_bank[i] = 8'hA0 + 8'(i);
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        chk("R10 reset sda_pull", int'(sda_pull), 0);
        chk("R5 reset wr_stb", int'(wr_stb), 0);
        chk("R7 reset rd_stb", int'(rd_stb), 0);

        // vector table: write one register, then read it back
        for (int i = 0; i < 8; i++) begin
            logic [7:0] p, d;
            p = VEC[i][15:8]; d = VEC[i][7:0];
            w0 = wr_cnt;
            h_start;
            h_send(wa(strap), a); chk("R1 write address ack", int'(a), 1);
            h_send(p, a);         chk("R4 pointer ack", int'(a), 1);
            h_send(d, a);         chk("R5 data ack", int'(a), 1);
            h_stop;
            chk("R5 one strobe per byte", wr_cnt - w0, 1);
            exp_bank[p[1:0]] = d;
            h_start;
            h_send(wa(strap), a);
            h_send(p, a);
            h_rstart;
            h_send(ra(strap), a); chk("R9 read address after rep start", int'(a), 1);
            h_recv(1'b0, b);      chk("R3 R7 read back", int'(b), int'(d));
            h_stop;
        end

        // R4: pointer-only write makes no strobe
        w0 = wr_cnt;
        h_start; h_send(wa(strap), a); h_send(8'h02, a); h_stop;
        chk("R4 pointer byte no write", wr_cnt - w0, 0);

        // R5: burst with wrap 3 -> 0 -> 1
        w0 = wr_cnt;
        h_start; h_send(wa(strap), a); h_send(8'h03, a);
        h_send(8'h11, a); h_send(8'h22, a); h_send(8'h33, a); h_stop;
        chk("R5 burst strobes", wr_cnt - w0, 3);
        exp_bank[3] = 8'h11; exp_bank[0] = 8'h22; exp_bank[1] = 8'h33;
        h_start; h_send(wa(strap), a); h_send(8'h03, a); h_rstart; h_send(ra(strap), a);
        h_recv(1'b1, b); chk("R7 burst byte 0", int'(b), 8'h11);
        h_recv(1'b1, b); chk("R7 burst byte 1", int'(b), 8'h22);
        h_recv(1'b0, b); chk("R7 burst byte 2", int'(b), 8'h33);
        h_stop;

        // R9: pointer kept (now 2); R8: after NACK nothing is driven
        h_start; h_send(ra(strap), a);
        h_recv(1'b0, b); chk("R9 pointer retained", int'(b), int'(exp_bank[2]));
        pull_cnt = 0;
        h_recv(1'b0, b);
        chk("R8 released after nack data", int'(b), 8'hFF);
        chk("R8 no pull after nack", pull_cnt, 0);
        h_stop;

        // R6 / R12: parallel mode drops writes, reads still work
        par = 1;
        w0 = wr_cnt;
        h_start; h_send(wa(strap), a); chk("R6 address ack in par", int'(a), 1);
        h_send(8'h01, a); h_send(8'h5A, a); chk("R6 data ack in par", int'(a), 1);
        h_stop;
        chk("R6 no strobe in par", wr_cnt - w0, 0);
        h_start; h_send(ra(strap), a);
        h_recv(1'b0, b); chk("R6 pointer advanced in par", int'(b), int'(exp_bank[2]));
        h_stop;
        h_start; h_send(wa(strap), a); h_send(8'h01, a); h_rstart; h_send(ra(strap), a);
        h_recv(1'b0, b); chk("R12 read in par unchanged", int'(b), int'(exp_bank[1]));
        h_stop;
        par = 0;

        // R2: mismatched address
        w0 = wr_cnt;
        h_start; h_send(8'h90, a); chk("R2 mismatch nack", int'(a), 0);
        pull_cnt = 0;
        h_send(8'h01, a); chk("R2 following byte nack", int'(a), 0);
        chk("R2 no pull after mismatch", pull_cnt, 0);
        h_stop;
        chk("R2 no write after mismatch", wr_cnt - w0, 0);

        // R1: straps move the address
        strap = 2'b10;
        h_start; h_send(wa(2'b01), a); chk("R1 old address refused", int'(a), 0); h_stop;
        h_start; h_send(wa(2'b10), a); chk("R1 new address ack", int'(a), 1);
        h_send(8'h00, a); h_send(8'h77, a); h_stop;
        exp_bank[0] = 8'h77;
        h_start; h_send(wa(2'b10), a); h_send(8'h00, a); h_rstart; h_send(ra(2'b10), a);
        h_recv(1'b0, b); chk("R1 write via new address", int'(b), 8'h77);
        h_stop;
        strap = 2'b01;

        // R10: stop after pointer keeps it, bus released
        h_start; h_send(wa(strap), a); h_send(8'h03, a); h_stop;
        chk("R10 released after stop", int'(sda_pull), 0);
        h_start; h_send(ra(strap), a);
        h_recv(1'b0, b); chk("R10 pointer kept over stop", int'(b), int'(exp_bank[3]));
        h_stop;

        chk("R11 no pull change while scl high", hi_chg, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule